// File: doc/BRIEF.md
# SDRAM Mode Register Write Monitor

This block sits beside a DDR SDRAM command bus, on the device side or as a passive bus observer. It samples the chip-select, row-strobe, column-strobe and write-enable pins together with the address, bank address, clock enable and a per-bank "row open" vector on every rising clock edge. When a register-load command passes all legality checks, it latches the base mode fields. It then presents the decoded burst length, burst ordering and read latency, plus a single-cycle pulse that requests a DLL reset.

The same sampling also checks the protocol around register loads. It raises a one-cycle flag for each of these: a load while a row is open, a load too soon after a precharge, any command inside the settling window after a load, a base load that arrives before any extended load, reserved length or latency codes, set test or spare bits, and reads or writes issued before the base register holds a defined value. A base load that raises any of these flags is dropped, and the decoded outputs keep their previous contents. Every output is registered, so a command sampled at edge k shows on the outputs just after edge k.

Top module: `sdram_mode_monitor`

## Requirements
- R1: A command is a register load when CKE is high and cs_n, ras_n, cas_n and we_n are all low. An accepted base load (ba[0]=0) sets mode_valid and sets burst_beats from addr[2:0]: 001→2, 010→4, 011→8, 111→PAGE_LEN. It also sets burst_interleave to addr[3] (1 = interleaved order).
- R2: An accepted base load sets cas_latency from addr[6:4]: 010→2, 011→3.
- R3: When CKE is low or cs_n is high, the sampled command counts as NOP. It changes no output and raises no flag.
- R4: A load of either register while any bit of bank_open is 1 raises err_bank_open one cycle later and is not accepted.
- R5: A precharge command ({ras_n,cas_n,we_n}=010) opens a window of TRP_CYC cycles. A load sampled fewer than TRP_CYC cycles after the precharge raises err_trp and is not accepted.
- R6: After an accepted load, any command other than NOP sampled in the next TMRD_CYC-1 cycles raises err_tmrd. If that command is a load, it is not accepted.
- R7: A base load issued before any accepted extended load (ba[0]=1) raises err_order and is not accepted. An accepted extended load changes none of the decoded outputs.
- R8: A base load with a burst code outside R1's list, with code 111 together with addr[3]=1, or with a latency code outside R2's list raises err_reserved and is not accepted.
- R9: A base load with addr[7]=1, any of addr[11:9] set, or ba[1]=1 raises err_test and is not accepted.
- R10: A read (101) or write (100) command sampled while mode_valid is 0 raises err_no_mode.
- R11: An accepted base load with addr[8]=1 drives dll_reset high for exactly one cycle.
- R12: After reset, mode_valid, burst_beats, burst_interleave, cas_latency, dll_reset and every flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock (rising edge) |
| rst_n | input | 1 | Active-low asynchronous reset |
| cke | input | 1 | Clock enable; low masks the command |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Address pins |
| ba | input | 2 | Bank address pins |
| bank_open | input | BANKS | One bit per bank, 1 = row open |
| mode_valid | output | 1 | Base register holds a defined value |
| burst_beats | output | BEAT_W | Decoded burst length in beats |
| burst_interleave | output | 1 | 1 = interleaved burst order |
| cas_latency | output | 2 | Decoded read latency in clocks |
| dll_reset | output | 1 | One-cycle DLL reset request |
| err_bank_open | output | 1 | Load while a row is open |
| err_trp | output | 1 | Load inside the precharge window |
| err_tmrd | output | 1 | Command inside the settling window |
| err_order | output | 1 | Base load before extended load |
| err_reserved | output | 1 | Reserved length or latency code |
| err_test | output | 1 | Test or spare bits set |
| err_no_mode | output | 1 | Read or write before a valid base load |

## Verification
The bench builds the block with TRP_CYC=4, TMRD_CYC=2 and PAGE_LEN=16. The wider precharge window lets loads land at the edge of the window, one cycle short of it and well inside it. The small page length keeps the full-page beat count inside a narrow output. A behavioural model follows every sampled command and is compared against all outputs on each clock. This covers back-to-back load sequences, masked commands, and loads that break several rules at once.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

    typedef enum logic [2:0] {
        CMD_LOAD  = 3'b000,
        CMD_REF   = 3'b001,
        CMD_PRE   = 3'b010,
        CMD_ACT   = 3'b011,
        CMD_WRITE = 3'b100,
        CMD_READ  = 3'b101,
        CMD_STOP  = 3'b110,
        CMD_NOP   = 3'b111
    } sdram_cmd_e;

    typedef struct packed {
        logic bank_open;
        logic trp;
        logic tmrd;
        logic order;
        logic reserved;
        logic test;
        logic no_mode;
    } viol_t;

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_mon_pkg::*;
(
    input  logic       cke,
    input  logic       cs_n,
    input  logic       ras_n,
    input  logic       cas_n,
    input  logic       we_n,
    output sdram_cmd_e cmd
);
    always_comb begin
        if (cke && !cs_n) begin
            cmd = sdram_cmd_e'({ras_n, cas_n, we_n});
        end else begin
            cmd = CMD_NOP;
        end
    end
endmodule

// File: rtl/sdram_mode_fields.sv
module sdram_mode_fields #(
    parameter int PAGE_LEN = 256,
    parameter int BEAT_W   = $clog2(PAGE_LEN + 1)
) (
    input  logic [6:0]        fld,
    output logic [BEAT_W-1:0] beats,
    output logic [1:0]        latency,
    output logic              len_bad,
    output logic              lat_bad
);
    always_comb begin
        beats   = '0;
        len_bad = 1'b0;
        case (fld[2:0])
            3'b001:  beats = BEAT_W'(2);
            3'b010:  beats = BEAT_W'(4);
            3'b011:  beats = BEAT_W'(8);
            3'b111: begin
                beats   = BEAT_W'(PAGE_LEN);
                len_bad = fld[3];
            end
            default: len_bad = 1'b1;
        endcase
    end

    always_comb begin
        latency = 2'd0;
        lat_bad = 1'b0;
        case (fld[6:4])
            3'b010:  latency = 2'd2;
            3'b011:  latency = 2'd3;
            default: lat_bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/sdram_window_timer.sv
module sdram_window_timer #(
    parameter int LEN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = CW'(LEN - 1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

    // R5 / R6: window never exceeds its configured length
    a_r5_r6_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LEN - 1));

    // R5 / R6: the window closes on its own when nothing restarts it
    a_r5_r6_window_drains: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start) |=> (cnt_q < $past(cnt_q)));
endmodule

// File: rtl/sdram_mode_monitor.sv
module sdram_mode_monitor
    import sdram_mon_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int BANKS    = 4,
    parameter int TRP_CYC  = 3,
    parameter int TMRD_CYC = 2,
    parameter int PAGE_LEN = 256,
    parameter int BEAT_W   = $clog2(PAGE_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        ba,
    input  logic [BANKS-1:0]  bank_open,
    output logic              mode_valid,
    output logic [BEAT_W-1:0] burst_beats,
    output logic              burst_interleave,
    output logic [1:0]        cas_latency,
    output logic              dll_reset,
    output logic              err_bank_open,
    output logic              err_trp,
    output logic              err_tmrd,
    output logic              err_order,
    output logic              err_reserved,
    output logic              err_test,
    output logic              err_no_mode
);
    typedef struct packed {
        logic              valid;
        logic              ext_seen;
        logic [BEAT_W-1:0] beats;
        logic              ilv;
        logic [1:0]        lat;
        logic              dll;
        viol_t             viol;
    } state_t;

    state_t     s_d, s_q;
    sdram_cmd_e cmd;
    logic [BEAT_W-1:0] dec_beats;
    logic [1:0]        dec_lat;
    logic              len_bad, lat_bad;
    logic              trp_busy, mrd_busy;
    logic              is_load, base_load, accept;

    sdram_cmd_decode u_cmd (
        .cke   (cke),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    sdram_mode_fields #(.PAGE_LEN(PAGE_LEN), .BEAT_W(BEAT_W)) u_fields (
        .fld     (addr[6:0]),
        .beats   (dec_beats),
        .latency (dec_lat),
        .len_bad (len_bad),
        .lat_bad (lat_bad)
    );

    sdram_window_timer #(.LEN(TRP_CYC)) u_trp (
        .clk   (clk),
        .rst_n (rst_n),
        .start (cmd == CMD_PRE),
        .busy  (trp_busy)
    );

    sdram_window_timer #(.LEN(TMRD_CYC)) u_mrd (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept),
        .busy  (mrd_busy)
    );

    always_comb begin
        s_d      = s_q;
        s_d.dll  = 1'b0;
        s_d.viol = '0;

        is_load   = (cmd == CMD_LOAD);
        base_load = is_load && !ba[0];

        s_d.viol.bank_open = is_load && (|bank_open);
        s_d.viol.trp       = is_load && trp_busy;
        s_d.viol.tmrd      = (cmd != CMD_NOP) && mrd_busy;
        s_d.viol.order     = base_load && !s_q.ext_seen;
        s_d.viol.reserved  = base_load && (len_bad || lat_bad);
        s_d.viol.test      = base_load && (addr[7] || (|addr[ADDR_W-1:9]) || ba[1]);
        s_d.viol.no_mode   = ((cmd == CMD_READ) || (cmd == CMD_WRITE)) && !s_q.valid;

        accept = is_load
              && !(s_d.viol.bank_open || s_d.viol.trp || s_d.viol.tmrd)
              && !(s_d.viol.order || s_d.viol.reserved || s_d.viol.test);

        if (accept) begin
            if (ba[0]) begin
                s_d.ext_seen = 1'b1;
            end else begin
                s_d.valid = 1'b1;
                s_d.beats = dec_beats;
                s_d.ilv   = addr[3];
                s_d.lat   = dec_lat;
                s_d.dll   = addr[8];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mode_valid       = s_q.valid;
    assign burst_beats      = s_q.beats;
    assign burst_interleave = s_q.ilv;
    assign cas_latency      = s_q.lat;
    assign dll_reset        = s_q.dll;
    assign err_bank_open    = s_q.viol.bank_open;
    assign err_trp          = s_q.viol.trp;
    assign err_tmrd         = s_q.viol.tmrd;
    assign err_order        = s_q.viol.order;
    assign err_reserved     = s_q.viol.reserved;
    assign err_test         = s_q.viol.test;
    assign err_no_mode      = s_q.viol.no_mode;

    a_r4_open_bank_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_LOAD && (|bank_open)) |=>
            (err_bank_open && $stable(burst_beats) && $stable(cas_latency)));

    a_r10_use_before_load: assert property (@(posedge clk) disable iff (!rst_n)
        (((cmd == CMD_READ) || (cmd == CMD_WRITE)) && !mode_valid) |=> err_no_mode);

    a_r7_ext_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_valid) |-> $past(s_q.ext_seen));

    a_r11_dll_single: assert property (@(posedge clk) disable iff (!rst_n)
        dll_reset |=> !dll_reset);

    a_r6_no_load_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        mrd_busy |=> !dll_reset);

    a_r3_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke || cs_n) |=> (!err_bank_open && !err_trp && !err_tmrd && !err_no_mode
                            && $stable(burst_beats) && $stable(mode_valid)));
endmodule

// File: tb/sdram_mode_monitor_bench.sv
module sdram_mode_monitor_bench;
    localparam int ADDR_W = 12, BANKS = 4, TRP = 4, TMRD = 2, PAGE = 16;
    localparam int BW = $clog2(PAGE + 1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [1:0] ba = '0;
    logic [BANKS-1:0] bank_open = '0;
    logic mode_valid, burst_interleave, dll_reset;
    logic [BW-1:0] burst_beats;
    logic [1:0] cas_latency;
    logic err_bank_open, err_trp, err_tmrd, err_order, err_reserved, err_test, err_no_mode;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // reference model state
    int m_valid, m_ext, m_beats, m_ilv, m_lat, m_dll;
    int m_eb, m_etrp, m_emrd, m_eord, m_eres, m_etst, m_enm;
    int trp_rem, mrd_rem;

    always #2.5 clk = ~clk;

    sdram_mode_monitor #(.ADDR_W(ADDR_W), .BANKS(BANKS), .TRP_CYC(TRP),
                         .TMRD_CYC(TMRD), .PAGE_LEN(PAGE)) u_sdram_mode_monitor (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .addr(addr), .ba(ba), .bank_open(bank_open),
        .mode_valid(mode_valid), .burst_beats(burst_beats),
        .burst_interleave(burst_interleave), .cas_latency(cas_latency),
        .dll_reset(dll_reset), .err_bank_open(err_bank_open), .err_trp(err_trp),
        .err_tmrd(err_tmrd), .err_order(err_order), .err_reserved(err_reserved),
        .err_test(err_test), .err_no_mode(err_no_mode));

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_valid = 0; m_ext = 0; m_beats = 0; m_ilv = 0; m_lat = 0; m_dll = 0;
        m_eb = 0; m_etrp = 0; m_emrd = 0; m_eord = 0; m_eres = 0; m_etst = 0; m_enm = 0;
        trp_rem = 0; mrd_rem = 0;
    endtask

    task automatic model_step();
        int code, bl, cl, ok, base, load;
        code = (cke && !cs_n) ? int'({ras_n, cas_n, we_n}) : 7;
        load = (code == 0);
        base = load && !ba[0];
        bl = 0; cl = 0;
        case (addr[2:0])
            3'd1: bl = 2;
            3'd2: bl = 4;
            3'd3: bl = 8;
            3'd7: bl = addr[3] ? -1 : PAGE;
            default: bl = -1;
        endcase
        case (addr[6:4])
            3'd2: cl = 2;
            3'd3: cl = 3;
            default: cl = -1;
        endcase
        m_eb   = load && (bank_open != 0);
        m_etrp = load && (trp_rem > 0);
        m_emrd = (code != 7) && (mrd_rem > 0);
        m_eord = base && !m_ext;
        m_eres = base && (bl < 0 || cl < 0);
        m_etst = base && (addr[7] || addr[11:9] != 0 || ba[1]);
        m_enm  = (code == 4 || code == 5) && !m_valid;
        ok = load && !m_eb && !m_etrp && !m_emrd && !m_eord && !m_eres && !m_etst;
        m_dll = 0;
        if (code == 2) trp_rem = TRP - 1; else if (trp_rem > 0) trp_rem--;
        if (ok) mrd_rem = TMRD - 1; else if (mrd_rem > 0) mrd_rem--;
        if (ok) begin
            if (ba[0]) m_ext = 1;
            else begin
                m_valid = 1; m_beats = bl; m_ilv = addr[3]; m_lat = cl; m_dll = addr[8];
            end
        end
    endtask

    task automatic compare_all();
        check("R1 mode_valid", mode_valid, m_valid);
        check("R1 burst_beats", burst_beats, m_beats);
        check("R1 burst_interleave", burst_interleave, m_ilv);
        check("R2 cas_latency", cas_latency, m_lat);
        check("R11 dll_reset", dll_reset, m_dll);
        check("R4 err_bank_open", err_bank_open, m_eb);
        check("R5 err_trp", err_trp, m_etrp);
        check("R6 err_tmrd", err_tmrd, m_emrd);
        check("R7 err_order", err_order, m_eord);
        check("R8 err_reserved", err_reserved, m_eres);
        check("R9 err_test", err_test, m_etst);
        check("R10 err_no_mode", err_no_mode, m_enm);
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        #1;
        compare_all();
    endtask

    task automatic cmd(input logic [2:0] c, input logic [ADDR_W-1:0] a, input logic [1:0] b);
        cke = 1'b1; cs_n = 1'b0; {ras_n, cas_n, we_n} = c; addr = a; ba = b;
        tick();
        cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b111; addr = '0; ba = '0;
    endtask

    task automatic nops(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    function automatic logic [ADDR_W-1:0] mr(int bl, int il, int cl, int dll, int tm);
        logic [ADDR_W-1:0] v = '0;
        v[2:0] = bl[2:0]; v[3] = il[0]; v[6:4] = cl[2:0]; v[7] = tm[0]; v[8] = dll[0];
        return v;
    endfunction

    initial begin
        #20000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int keep;
        model_reset();
        #12 rst_n = 1'b1;
        #1;
        compare_all();                       // R12 reset state
        check("R12 reset mode_valid", mode_valid, 0);
        nops(1);
        cmd(3'b101, '0, 2'd0);               // R10 read before load
        check("R10 read flagged", err_no_mode, 1);
        nops(1);
        cmd(3'b000, mr(2, 0, 2, 0, 0), 2'd0); // R7 base before extended
        check("R7 order flagged", err_order, 1);
        nops(2);
        cmd(3'b000, '0, 2'd1);               // extended load
        cmd(3'b000, mr(2, 0, 2, 0, 0), 2'd0); // R6 inside settling window
        check("R6 window flagged", err_tmrd, 1);
        check("R6 load dropped", mode_valid, 0);
        nops(2);
        cmd(3'b000, mr(2, 0, 2, 0, 0), 2'd0); // R1/R2 BL4 seq CL2
        check("R1 beats 4", burst_beats, 4);
        check("R2 latency 2", cas_latency, 2);
        nops(2);
        keep = burst_beats;
        cke = 1'b0; cs_n = 1'b0; {ras_n, cas_n, we_n} = 3'b000; addr = mr(3, 1, 3, 1, 0);
        tick();                              // R3 masked by CKE
        cke = 1'b1; cs_n = 1'b1;
        tick();                              // R3 masked by chip select
        {ras_n, cas_n, we_n} = 3'b111;
        check("R3 masked load ignored", burst_beats, keep);
        nops(1);
        bank_open = 4'b0100;
        cmd(3'b000, mr(3, 0, 3, 0, 0), 2'd0); // R4
        check("R4 open bank flagged", err_bank_open, 1);
        bank_open = '0;
        nops(1);
        cmd(3'b010, 12'h400, 2'd0);          // precharge all
        nops(2);
        cmd(3'b000, mr(3, 1, 3, 1, 0), 2'd0); // R5 one short of window
        check("R5 early load flagged", err_trp, 1);
        cmd(3'b000, mr(3, 1, 3, 1, 0), 2'd0); // exactly TRP after precharge, R11
        check("R5 load at window edge", err_trp, 0);
        check("R11 dll pulse", dll_reset, 1);
        tick();
        check("R11 dll pulse ends", dll_reset, 0);
        nops(1);
        cmd(3'b000, mr(0, 0, 2, 0, 0), 2'd0); // R8 length code 000
        nops(2);
        cmd(3'b000, mr(2, 0, 4, 0, 0), 2'd0); // R8 latency code 100
        nops(2);
        cmd(3'b000, mr(7, 1, 2, 0, 0), 2'd0); // R8 full page interleaved
        check("R8 full page interleave", err_reserved, 1);
        nops(2);
        cmd(3'b000, mr(1, 0, 2, 0, 1), 2'd0); // R9 test bit
        check("R9 test flagged", err_test, 1);
        nops(2);
        cmd(3'b000, mr(1, 0, 2, 0, 0) | 12'h200, 2'd2); // R9 spare bits
        nops(2);
        cmd(3'b000, mr(7, 0, 3, 0, 0), 2'd0); // R1 full page sequential
        check("R1 full page", burst_beats, PAGE);
        nops(2);
        cmd(3'b000, mr(1, 0, 2, 0, 0) | 12'h100, 2'd0); // R1 BL2 with dll
        cmd(3'b011, '0, 2'd0);               // R6 activate in window
        nops(1);
        cmd(3'b101, '0, 2'd0);               // R10 read after load: no flag
        check("R10 read after load", err_no_mode, 0);
        nops(3);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule